// File: doc/BRIEF.md
# Debug Break Injector

This block sits beside a CPU's instruction sequencer and turns a break-address match into a software interrupt. It does not redirect the core mid-instruction. A match is remembered until the sequencer reports the last cycle of the instruction in progress. On that boundary the block replaces the next opcode with a software-interrupt opcode and loads the program counter with a vector address. The vector address differs between monitor mode and normal operation.

When the match arrives on the last cycle itself, the injection happens in that same cycle, with no added delay. Once a break is taken, the block reports that it is active and ignores further matches. A return-from-interrupt strobe ends the active state, but only when the break request level has already been withdrawn.

Top module: `brk_inject`

## Requirements
- R1: While `rst_n` is low, `ir_load`, `pc_load` and `brk_active` stay 0 whatever the other inputs are. After reset is released, there is no pending or active break.
- R2: A `brk_match` seen while `last_cyc` is 0 causes no strobe in that cycle. It is held pending, and injection happens on the first later cycle with `last_cyc` = 1, even if the match pulse is gone by then.
- R3: A `brk_match` in a cycle with `last_cyc` = 1 and no active break raises `ir_load` and `pc_load` in that same cycle.
- R4: Whenever `ir_load` is 1, `ir_opcode` equals the parameter SWI_OP, which defaults to 8'h83.
- R5: During injection, `pc_vector` is 16'hFFFC when `mon_mode` is 0 and 16'hFEFC when `mon_mode` is 1. It is sampled in the injecting cycle.
- R6: `brk_active` becomes 1 in the cycle after an injection and stays 1 until a qualifying return.
- R7: While `brk_active` is 1, `brk_match` produces no strobe and leaves nothing pending. After the break ends, a boundary cycle with no new match injects nothing.
- R8: `rti_done` = 1 with `brk_level` = 0 while active clears `brk_active` in the next cycle. `rti_done` while inactive has no effect.
- R9: `rti_done` = 1 with `brk_level` = 1 while active leaves `brk_active` at 1.
- R10: `ir_load` and `pc_load` are always equal, and each one is high for exactly one cycle per break taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_match | input | 1 | Match pulse from the break address comparator |
| last_cyc | input | 1 | High in the final cycle of the current instruction |
| mon_mode | input | 1 | Monitor mode selects the alternate vector |
| rti_done | input | 1 | Strobe: a return-from-interrupt was executed |
| brk_level | input | 1 | Break request level still asserted by the break source |
| ir_load | output | 1 | Load the instruction register with `ir_opcode` |
| ir_opcode | output | 8 | Software-interrupt opcode |
| pc_load | output | 1 | Load the program counter from the vector pair |
| pc_vector | output | 16 | Address of the high byte of the vector pair |
| brk_active | output | 1 | Break service in progress |

## Verification
Matches are driven in four ways: on a boundary cycle, in the middle of an instruction followed by a long run of non-boundary cycles, as repeated pulses during an active break, and during reset. Together these separate immediate injection from deferred injection, and they show whether a pending flag is kept or dropped. Returns are issued with the break level both high and low, and also while no break is active, which tells a qualified exit from an unconditional one. A random phase then toggles monitor mode at injection time and mixes all inputs, and a behavioural model compares the outputs on every cycle.

// File: rtl/brk_inject.sv
module brk_inject #(
  parameter int          AW       = 16,
  parameter logic [7:0]  SWI_OP   = 8'h83,
  parameter logic [AW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_match,
  input  logic          last_cyc,
  input  logic          mon_mode,
  input  logic          rti_done,
  input  logic          brk_level,
  output logic          ir_load,
  output logic [7:0]    ir_opcode,
  output logic          pc_load,
  output logic [AW-1:0] pc_vector,
  output logic          brk_active
);

  logic pending;
  logic active;
  logic inject;

  assign inject    = rst_n && last_cyc && !active && (pending || brk_match);
  assign ir_load   = inject;
  assign pc_load   = inject;
  assign ir_opcode = SWI_OP;
  assign pc_vector = mon_mode ? VEC_MON : VEC_NORM;
  assign brk_active = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (inject) begin
      pending <= 1'b0;
    end else if (!active && brk_match) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (inject) begin
      active <= 1'b1;
    end else if (active && rti_done && !brk_level) begin
      active <= 1'b0;
    end
  end

endmodule

module brk_inject_chk #(
  parameter int          AW       = 16,
  parameter logic [7:0]  SWI_OP   = 8'h83,
  parameter logic [AW-1:0] VEC_NORM = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MON  = 16'hFEFC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          brk_match,
  input logic          last_cyc,
  input logic          mon_mode,
  input logic          rti_done,
  input logic          brk_level,
  input logic          ir_load,
  input logic [7:0]    ir_opcode,
  input logic          pc_load,
  input logic [AW-1:0] pc_vector,
  input logic          brk_active
);

  assert_boundary_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> last_cyc);

  assert_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_match && last_cyc && !brk_active) |-> ir_load);

  assert_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> (ir_opcode == SWI_OP));

  assert_mon_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && mon_mode) |-> (pc_vector == VEC_MON));

  assert_norm_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !mon_mode) |-> (pc_vector == VEC_NORM));

  assert_goes_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> brk_active);

  assert_no_reinject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> !pc_load);

  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && rti_done && !brk_level) |=> !brk_active);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && rti_done && brk_level) |=> brk_active);

  assert_paired_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load == pc_load);

endmodule

bind brk_inject brk_inject_chk #(
  .AW(AW), .SWI_OP(SWI_OP), .VEC_NORM(VEC_NORM), .VEC_MON(VEC_MON)
) u_brk_inject_chk (
  .clk(clk), .rst_n(rst_n), .brk_match(brk_match), .last_cyc(last_cyc),
  .mon_mode(mon_mode), .rti_done(rti_done), .brk_level(brk_level),
  .ir_load(ir_load), .ir_opcode(ir_opcode), .pc_load(pc_load),
  .pc_vector(pc_vector), .brk_active(brk_active)
);

// File: tb/test_brk_inject.sv
module test_brk_inject;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_match = 1'b0, last_cyc = 1'b0, mon_mode = 1'b0, rti_done = 1'b0, brk_level = 1'b0;
  logic ir_load, pc_load, brk_active;
  logic [7:0] ir_opcode;
  logic [15:0] pc_vector;

  int vectors = 0;
  int errors = 0;
  int m_pend = 0;
  int m_act = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brk_inject i_brk_inject (
    .clk(clk), .rst_n(rst_n), .brk_match(brk_match), .last_cyc(last_cyc),
    .mon_mode(mon_mode), .rti_done(rti_done), .brk_level(brk_level),
    .ir_load(ir_load), .ir_opcode(ir_opcode), .pc_load(pc_load),
    .pc_vector(pc_vector), .brk_active(brk_active)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit m, input bit l, input bit mon,
                      input bit rti, input bit lvl, input string req);
    int inj;
    @(negedge clk);
    rst_n = r; brk_match = m; last_cyc = l; mon_mode = mon; rti_done = rti; brk_level = lvl;
    #5;
    inj = (r && l && m_act == 0 && (m_pend != 0 || m)) ? 1 : 0;
    chk(req, "ir_load", int'(ir_load), inj);
    chk("R10", "pc_load", int'(pc_load), inj);
    chk(req, "brk_active", int'(brk_active), r ? m_act : 0);
    if (inj != 0) begin
      chk("R4", "ir_opcode", int'(ir_opcode), 8'h83);
      chk("R5", "pc_vector", int'(pc_vector), mon ? 16'hFEFC : 16'hFFFC);
    end
    if (!r) begin
      m_pend = 0; m_act = 0;
    end else begin
      if (inj != 0) begin m_pend = 0; m_act = 1; end
      else if (m_act == 0 && m) m_pend = 1;
      else if (m_act != 0 && rti && !lvl) m_act = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 0, "R1");
    step(1, 0, 1, 0, 0, 0, "R1");
    // immediate injection, normal vector
    step(1, 1, 1, 0, 0, 1, "R3");
    step(1, 0, 0, 0, 0, 1, "R6");
    // matches while active are ignored
    step(1, 1, 1, 0, 0, 1, "R7");
    step(1, 1, 0, 0, 0, 1, "R7");
    // return with level still high
    step(1, 0, 1, 0, 1, 1, "R9");
    step(1, 0, 0, 0, 0, 1, "R9");
    // return with level removed
    step(1, 0, 1, 0, 1, 0, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 1, 0, 0, 0, "R7");
    step(1, 0, 1, 1, 0, 0, "R7");
    // mid-instruction match, monitor vector
    step(1, 1, 0, 1, 0, 1, "R2");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 1, "R2");
    step(1, 0, 1, 1, 0, 1, "R2");
    step(1, 0, 1, 1, 0, 1, "R10");
    step(1, 0, 0, 1, 1, 0, "R8");
    // return while idle has no effect
    step(1, 0, 1, 0, 1, 0, "R8");
    step(1, 0, 0, 0, 1, 0, "R8");
    // pending, mode changes before boundary
    step(1, 1, 0, 1, 0, 0, "R2");
    step(1, 0, 1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 1, 0, "R8");
    // reset drops a pending request
    step(1, 1, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 1, 0, 0, 0, "R1");
    for (int i = 0; i < 600; i++)
      step(1, ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom % 2,
           ($urandom % 4) == 0, $urandom % 2, "R10");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule